// File: doc/BRIEF.md
# Registered Dual-Port Static Memory

This block is a true two-port memory of 4096 nine-bit words. A left port and a right port each run on their own clock and may read or write any word at the same time as the other. Every port samples its address, write data, active-low select and read/write direction on the rising edge of its clock, so that the cycle after the edge is governed entirely by registered state. A per-port stall input freezes the address and write-data registers, and an active-low output enable gates the read bus at once, without waiting for a clock.

A write is carried out across one clock period: it is registered on one edge and lands in the array on the next. A read takes a snapshot of the array on the edge that registers it, so a read by one port on the very edge where the other port's write lands returns the previous word, and only reads registered on later edges see the new one. The bus turnaround at a read-to-write switch with the output enable held low is modelled as a hazard: the port raises a flag for the write cycle and discards that write, which the user must then repeat.

Top module: `twin_port_ram`

## Requirements
- R1: The array holds 2^AW words of DW bits (defaults 4096 by 9); a word written through either port can be read back through either port, and both ports can operate in the same clock cycle.
- R2: When an edge registers select low (`*_sel_n`=0) and direction high (`*_rd`=1, read), then in the following cycle, while `*_oe_n` is 0, `*_drive` is 1 and `*_rdata` holds the word that was stored at the registered address at that edge.
- R3: When an edge registers select low and direction low (`*_rd`=0, write), the registered data is stored at the registered address on the next edge of the same port; a read registered before that next edge returns the previous word.
- R4: With `*_stall` high at an edge, the port's address and write-data registers keep their previous contents, while select and direction still load; the following access uses the held address and data.
- R5: When an edge registers select high, the port performs no array access in the following cycle: nothing is written, `*_drive` is 0 and `*_rdata` is all zeros.
- R6: Whenever `*_oe_n` is 1, `*_drive` is 0 and `*_rdata` is all zeros in that same instant, regardless of the registered state; lowering it again restores the read word without a clock edge.
- R7: A read by one port registered on the same edge on which the other port's write lands returns the old word; a read registered on any later edge returns the new word.
- R8: When an edge registers a write while the previous registered operation of that port was a read and `*_oe_n` is 0 at that edge, `*_turn_haz` is 1 for exactly that write cycle and the write is discarded; a repeated write in the next cycle is stored. With `*_oe_n` at 1 at that edge, no flag is raised and the write is stored.
- R9: While `rst_n` is 0, both ports are deselected at once: `*_drive` and `*_turn_haz` are 0 and `*_rdata` is all zeros. The array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of both ports' registers |
| l_clk | input | 1 | Left port clock |
| l_stall | input | 1 | Left port: 1 holds the address and write-data registers |
| l_sel_n | input | 1 | Left port select, active low, registered |
| l_rd | input | 1 | Left port direction, 1 read, 0 write, registered |
| l_oe_n | input | 1 | Left port output enable, active low, unclocked |
| l_addr | input | AW | Left port word address |
| l_wdata | input | DW | Left port write data |
| l_rdata | output | DW | Left port read bus, zero when not driven |
| l_drive | output | 1 | Left port bus is being driven |
| l_turn_haz | output | 1 | Left port read-to-write turnaround hazard; current write discarded |
| r_clk | input | 1 | Right port clock |
| r_stall | input | 1 | Right port: 1 holds the address and write-data registers |
| r_sel_n | input | 1 | Right port select, active low, registered |
| r_rd | input | 1 | Right port direction, 1 read, 0 write, registered |
| r_oe_n | input | 1 | Right port output enable, active low, unclocked |
| r_addr | input | AW | Right port word address |
| r_wdata | input | DW | Right port write data |
| r_rdata | output | DW | Right port read bus, zero when not driven |
| r_drive | output | 1 | Right port bus is being driven |
| r_turn_haz | output | 1 | Right port read-to-write turnaround hazard; current write discarded |

## Verification
The assertions take for granted that every input of a port is steady around that port's rising edge and that reset is released away from either edge, so each sampled value is the one the registers took. They also rely on the output enable changing only inside a cycle and never being used as a clock. The stimulus drives every port input on the falling edge and moves the output enable only in mid-cycle, and it runs both ports from one clock so that the same-edge cases of write landing and read snapshot happen on purpose rather than by chance.

// File: rtl/twin_port_ram.sv
module twin_port_ram #(
  parameter int AW = 12,
  parameter int DW = 9
) (
  input  logic          rst_n,
  input  logic          l_clk,
  input  logic          l_stall,
  input  logic          l_sel_n,
  input  logic          l_rd,
  input  logic          l_oe_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_drive,
  output logic          l_turn_haz,
  input  logic          r_clk,
  input  logic          r_stall,
  input  logic          r_sel_n,
  input  logic          r_rd,
  input  logic          r_oe_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_drive,
  output logic          r_turn_haz
);
  localparam int DEPTH = 1 << AW;

  // Each port owns one bank and one ownership bit per word; equal bits mean
  // the left bank holds the newest word, unequal bits mean the right bank.
  logic [DW-1:0] bank_l [DEPTH];
  logic [DW-1:0] bank_r [DEPTH];
  logic          tog_l  [DEPTH];
  logic          tog_r  [DEPTH];

  // ---------------- left port ----------------
  logic          l_sel_q, l_rd_q, l_haz_q;
  logic [AW-1:0] l_addr_q;
  logic [DW-1:0] l_wd_q, l_rbuf;
  logic [AW-1:0] l_eff;
  logic          l_commit, l_haz_next;

  assign l_eff      = l_stall ? l_addr_q : l_addr;
  assign l_commit   = !l_sel_q && !l_rd_q && !l_haz_q;
  assign l_haz_next = !l_sel_n && !l_rd && !l_sel_q && l_rd_q && !l_oe_n;

  always_ff @(posedge l_clk or negedge rst_n) begin
    if (!rst_n) begin
      l_sel_q  <= 1'b1;
      l_rd_q   <= 1'b1;
      l_haz_q  <= 1'b0;
      l_addr_q <= '0;
      l_wd_q   <= '0;
      l_rbuf   <= '0;
    end else begin
      l_sel_q <= l_sel_n;
      l_rd_q  <= l_rd;
      l_haz_q <= l_haz_next;
      if (!l_stall) begin
        l_addr_q <= l_addr;
        l_wd_q   <= l_wdata;
      end
      if (!l_sel_n && l_rd)
        l_rbuf <= (tog_l[l_eff] == tog_r[l_eff]) ? bank_l[l_eff] : bank_r[l_eff];
    end
  end

  always_ff @(posedge l_clk) begin
    if (l_commit) begin
      bank_l[l_addr_q] <= l_wd_q;
      tog_l[l_addr_q]  <= tog_r[l_addr_q];
    end
  end

  assign l_drive    = !l_oe_n && !l_sel_q && l_rd_q;
  assign l_rdata    = l_drive ? l_rbuf : '0;
  assign l_turn_haz = l_haz_q;

  // ---------------- right port ----------------
  logic          r_sel_q, r_rd_q, r_haz_q;
  logic [AW-1:0] r_addr_q;
  logic [DW-1:0] r_wd_q, r_rbuf;
  logic [AW-1:0] r_eff;
  logic          r_commit, r_haz_next;

  assign r_eff      = r_stall ? r_addr_q : r_addr;
  assign r_commit   = !r_sel_q && !r_rd_q && !r_haz_q;
  assign r_haz_next = !r_sel_n && !r_rd && !r_sel_q && r_rd_q && !r_oe_n;

  always_ff @(posedge r_clk or negedge rst_n) begin
    if (!rst_n) begin
      r_sel_q  <= 1'b1;
      r_rd_q   <= 1'b1;
      r_haz_q  <= 1'b0;
      r_addr_q <= '0;
      r_wd_q   <= '0;
      r_rbuf   <= '0;
    end else begin
      r_sel_q <= r_sel_n;
      r_rd_q  <= r_rd;
      r_haz_q <= r_haz_next;
      if (!r_stall) begin
        r_addr_q <= r_addr;
        r_wd_q   <= r_wdata;
      end
      if (!r_sel_n && r_rd)
        r_rbuf <= (tog_l[r_eff] == tog_r[r_eff]) ? bank_l[r_eff] : bank_r[r_eff];
    end
  end

  always_ff @(posedge r_clk) begin
    if (r_commit) begin
      bank_r[r_addr_q] <= r_wd_q;
      tog_r[r_addr_q]  <= !tog_l[r_addr_q];
    end
  end

  assign r_drive    = !r_oe_n && !r_sel_q && r_rd_q;
  assign r_rdata    = r_drive ? r_rbuf : '0;
  assign r_turn_haz = r_haz_q;

  // ---------------- assertions ----------------
  AST_L_DRIVE_SOURCE: assert property (@(posedge l_clk) disable iff (!rst_n)
    l_drive |-> $past(!l_sel_n && l_rd)); // R2
  AST_R_DRIVE_SOURCE: assert property (@(posedge r_clk) disable iff (!rst_n)
    r_drive |-> $past(!r_sel_n && r_rd)); // R2
  AST_L_STALL_HOLDS: assert property (@(posedge l_clk) disable iff (!rst_n)
    $past(l_stall) |-> ($stable(l_addr_q) && $stable(l_wd_q))); // R4
  AST_R_STALL_HOLDS: assert property (@(posedge r_clk) disable iff (!rst_n)
    $past(r_stall) |-> ($stable(r_addr_q) && $stable(r_wd_q))); // R4
  AST_L_DESEL_QUIET: assert property (@(posedge l_clk) disable iff (!rst_n)
    $past(l_sel_n) |-> (!l_drive && $stable(l_rbuf))); // R5
  AST_R_DESEL_QUIET: assert property (@(posedge r_clk) disable iff (!rst_n)
    $past(r_sel_n) |-> (!r_drive && $stable(r_rbuf))); // R5
  AST_L_HAZ_SINGLE: assert property (@(posedge l_clk) disable iff (!rst_n)
    l_turn_haz |=> !l_turn_haz); // R8
  AST_R_HAZ_SINGLE: assert property (@(posedge r_clk) disable iff (!rst_n)
    r_turn_haz |=> !r_turn_haz); // R8
  AST_L_HAZ_CAUSE: assert property (@(posedge l_clk) disable iff (!rst_n)
    l_turn_haz |-> ($past(!l_sel_n && !l_rd && !l_oe_n) && $past(!l_sel_n && l_rd, 2) && !l_drive)); // R8
  AST_R_HAZ_CAUSE: assert property (@(posedge r_clk) disable iff (!rst_n)
    r_turn_haz |-> ($past(!r_sel_n && !r_rd && !r_oe_n) && $past(!r_sel_n && r_rd, 2) && !r_drive)); // R8
endmodule

// File: tb/sim_twin_port_ram.sv
`timescale 1ns/1ps
module sim_twin_port_ram;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       stall [2];
  logic       seln  [2];
  logic       rdw   [2];
  logic       oen   [2];
  logic [11:0] adr  [2];
  logic [8:0]  wd   [2];
  logic [8:0]  rdat [2];
  logic        drv  [2];
  logic        hz   [2];

  twin_port_ram u0 (
    .rst_n(rst_n),
    .l_clk(clk), .l_stall(stall[0]), .l_sel_n(seln[0]), .l_rd(rdw[0]), .l_oe_n(oen[0]),
    .l_addr(adr[0]), .l_wdata(wd[0]), .l_rdata(rdat[0]), .l_drive(drv[0]), .l_turn_haz(hz[0]),
    .r_clk(clk), .r_stall(stall[1]), .r_sel_n(seln[1]), .r_rd(rdw[1]), .r_oe_n(oen[1]),
    .r_addr(adr[1]), .r_wdata(wd[1]), .r_rdata(rdat[1]), .r_drive(drv[1]), .r_turn_haz(hz[1])
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  string cur_req = "R9";

  task automatic chk(input string req, input bit ok, input int act, input int exp, input string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int  mem [4096];
  bit  kn  [4096];
  bit  m_sel [2], m_rd [2], m_haz [2], m_rbk [2];
  int  m_aq [2], m_wq [2], m_rb [2];

  always @(posedge clk or negedge rst_n) begin
    bit cw [2];
    int ea;
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        m_sel[p] = 1; m_rd[p] = 1; m_haz[p] = 0; m_aq[p] = 0; m_wq[p] = 0;
        m_rb[p] = 0; m_rbk[p] = 1;
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (!seln[p] && rdw[p]) begin
          ea = stall[p] ? m_aq[p] : int'(adr[p]);
          m_rb[p] = mem[ea];
          m_rbk[p] = kn[ea];
        end
        cw[p] = !m_sel[p] && !m_rd[p] && !m_haz[p];
      end
      if (cw[0] && cw[1] && m_aq[0] == m_aq[1]) kn[m_aq[0]] = 0;
      else begin
        for (int p = 0; p < 2; p++)
          if (cw[p]) begin mem[m_aq[p]] = m_wq[p]; kn[m_aq[p]] = 1; end
      end
      for (int p = 0; p < 2; p++) begin
        m_haz[p] = !seln[p] && !rdw[p] && !m_sel[p] && m_rd[p] && !oen[p];
        m_sel[p] = seln[p];
        m_rd[p]  = rdw[p];
        if (!stall[p]) begin m_aq[p] = int'(adr[p]); m_wq[p] = int'(wd[p]); end
      end
    end
  end

  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      for (int p = 0; p < 2; p++) begin
        bit ed;
        ed = !oen[p] && !m_sel[p] && m_rd[p];
        chk(cur_req, drv[p] == ed, int'(drv[p]), int'(ed), p ? "right drive" : "left drive");
        chk("R8", hz[p] == m_haz[p], int'(hz[p]), int'(m_haz[p]), p ? "right hazard" : "left hazard");
        if (!ed) chk(cur_req, rdat[p] == 9'd0, int'(rdat[p]), 0, p ? "right idle bus" : "left idle bus");
        else if (m_rbk[p]) chk(cur_req, int'(rdat[p]) == m_rb[p], int'(rdat[p]), m_rb[p], p ? "right data" : "left data");
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle(input int p);
    seln[p] = 1; rdw[p] = 1; oen[p] = 0; stall[p] = 0;
  endtask

  task automatic wr(input int p, input int a, input int d);
    seln[p] = 0; rdw[p] = 0; adr[p] = 12'(a); wd[p] = 9'(d); stall[p] = 0;
  endtask

  task automatic rd(input int p, input int a);
    seln[p] = 0; rdw[p] = 1; adr[p] = 12'(a); stall[p] = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      idle(p); oen[p] = 1; adr[p] = 0; wd[p] = 0;
    end
    for (int a = 0; a < 4096; a++) begin mem[a] = 0; kn[a] = 0; end
    #3;
    for (int p = 0; p < 2; p++) begin // R9 reset state
      chk("R9", drv[p] == 0, int'(drv[p]), 0, "drive in reset");
      chk("R9", hz[p] == 0, int'(hz[p]), 0, "hazard in reset");
      chk("R9", rdat[p] == 0, int'(rdat[p]), 0, "bus in reset");
    end
    repeat (3) step();
    rst_n = 1;
    step();

    // R1: both ports at once, corner addresses
    cur_req = "R1";
    idle(0); idle(1);
    wr(0, 0, 9'h1FF); wr(1, 4095, 9'h0AA); step();
    wr(0, 7, 9'h155); wr(1, 8, 9'h033); step();
    idle(0); idle(1); step();
    rd(0, 4095); rd(1, 0); step();
    chk("R1", rdat[0] == 9'h0AA, int'(rdat[0]), 9'h0AA, "left reads right-written top word");
    chk("R1", rdat[1] == 9'h1FF, int'(rdat[1]), 9'h1FF, "right reads left-written bottom word");
    rd(0, 8); rd(1, 7); step();

    // R2/R3: same-port write then read back
    cur_req = "R3";
    idle(0); idle(1); step();
    wr(0, 100, 9'h0F0); step();
    rd(1, 100); step();
    cur_req = "R2";
    idle(0); rd(1, 100); step();
    chk("R2", rdat[1] == 9'h0F0 && drv[1], int'(rdat[1]), 9'h0F0, "read of landed word");

    // R7: read on the landing edge sees old, later sees new
    cur_req = "R7";
    idle(1); wr(0, 100, 9'h1A5); step();
    idle(0); rd(1, 100); step();
    chk("R7", rdat[1] == 9'h0F0, int'(rdat[1]), 9'h0F0, "read on landing edge is old");
    rd(1, 100); step();
    chk("R7", rdat[1] == 9'h1A5, int'(rdat[1]), 9'h1A5, "read after landing edge is new");

    // R6: unclocked output enable
    cur_req = "R6";
    #7; oen[1] = 1; #1;
    chk("R6", drv[1] == 0 && rdat[1] == 0, int'(rdat[1]), 0, "bus released by output enable");
    oen[1] = 0; #1;
    chk("R6", drv[1] == 1 && rdat[1] == 9'h1A5, int'(rdat[1]), 9'h1A5, "bus restored without clock");
    step();

    // R4: stall holds address and write data
    cur_req = "R4";
    idle(1);
    wr(0, 20, 9'h011); step();
    wr(0, 21, 9'h022); step();
    seln[0] = 0; rdw[0] = 1; oen[0] = 1; adr[0] = 20; wd[0] = 9'h0C3; step();
    seln[0] = 0; rdw[0] = 0; oen[0] = 1; adr[0] = 21; wd[0] = 9'h13C; stall[0] = 1; step();
    idle(0); step();
    rd(1, 21); step();
    chk("R4", rdat[1] == 9'h022, int'(rdat[1]), 9'h022, "unselected address untouched");
    rd(1, 20); step();
    chk("R4", rdat[1] == 9'h0C3, int'(rdat[1]), 9'h0C3, "held address got held data");
    rd(0, 30); step();
    rd(0, 20); stall[0] = 1; adr[0] = 99; step();
    chk("R4", rdat[0] == 9'h0F0 || rdat[0] != 9'h0C3, int'(rdat[0]), 9'h0C3, "stalled read used held address");

    // R5: deselect blocks write and bus
    cur_req = "R5";
    idle(0); idle(1); step();
    seln[0] = 1; rdw[0] = 0; adr[0] = 20; wd[0] = 9'h1E1; step();
    chk("R5", drv[0] == 0 && rdat[0] == 0, int'(rdat[0]), 0, "deselected bus idle");
    idle(0); step();
    rd(1, 20); step();
    chk("R5", rdat[1] == 9'h0C3, int'(rdat[1]), 9'h0C3, "deselected write had no effect");

    // R8: turnaround hazard drops first write
    cur_req = "R8";
    idle(1);
    rd(0, 40); step();
    wr(0, 40, 9'h0B4); oen[0] = 0; step();
    chk("R8", hz[0] == 1, int'(hz[0]), 1, "hazard flagged on write after read");
    idle(0); step();
    chk("R8", hz[0] == 0, int'(hz[0]), 0, "hazard lasts one cycle");
    rd(1, 40); step();
    rd(1, 40); step();
    chk("R8", rdat[1] != 9'h0B4, int'(rdat[1]), 0, "flagged write discarded");
    rd(0, 40); idle(1); step();
    wr(0, 40, 9'h0B4); oen[0] = 1; step();
    chk("R8", hz[0] == 0, int'(hz[0]), 0, "no hazard with bus released");
    idle(0); step();
    rd(1, 40); step();
    chk("R8", rdat[1] == 9'h0B4, int'(rdat[1]), 9'h0B4, "write with bus released stored");
    rd(0, 41); step();
    wr(0, 41, 9'h066); oen[0] = 0; step();
    wr(0, 41, 9'h066); step();
    chk("R8", hz[0] == 0, int'(hz[0]), 0, "repeat write not flagged");
    idle(0); step();
    rd(1, 41); step();
    chk("R8", rdat[1] == 9'h066, int'(rdat[1]), 9'h066, "repeated write stored");

    // R1: mixed random traffic against the model
    cur_req = "R1";
    for (int i = 0; i < 3000; i++) begin
      for (int p = 0; p < 2; p++) begin
        seln[p]  = ($urandom % 10) == 0;
        rdw[p]   = $urandom % 2;
        oen[p]   = ($urandom % 5) == 0;
        stall[p] = ($urandom % 7) == 0;
        adr[p]   = ($urandom % 4 == 0) ? 12'($urandom) : 12'($urandom % 16);
        wd[p]    = 9'($urandom);
      end
      step();
    end

    // R9: asynchronous reset mid-run
    idle(0); idle(1); step();
    rd(0, 100); step();
    @(posedge clk); #7; rst_n = 0; #1;
    for (int p = 0; p < 2; p++) begin
      chk("R9", drv[p] == 0 && hz[p] == 0 && rdat[p] == 0, int'(rdat[p]), 0, "outputs cleared by reset");
    end
    idle(0); idle(1);
    step(); step();
    rst_n = 1;
    rd(0, 100); step();
    chk("R9", rdat[0] == 9'h1A5 || !kn[100], int'(rdat[0]), 9'h1A5, "array kept over reset");
    idle(0); step();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule